// File: doc/BRIEF.md
# Dual-channel SAR converter readout sequencer

This block runs one conversion-and-readout cycle on a two-channel 13-bit sampling converter from the host side. A cycle raises the convert strobe and holds it high for a set number of cycles. It then waits out the worst-case conversion time and drives a shift clock. On every rising edge of that clock it captures the two serial data lines together, one line per channel. Both captured words are handed out sign-extended to 16 bits, with a one-cycle valid pulse.

All timing is counted in system-clock cycles and set through parameters. Elaboration stops with an error when a parameter set would break the converter's minimum convert-high time, conversion time, shift-clock phase width, shift-clock period or cycle period, when a readout cannot finish inside the minimum cycle, or when the conversion wait would end before the convert strobe falls. Each conversion is started by a pulse on `start_i` or by holding `free_run_i`. A request that arrives mid-cycle is remembered and carried out at the earliest legal moment.

Top module: `adc_dual_readout`

## Requirements
- R1: The convert strobe `cnv_o` stays high for exactly `CNV_HI_CYC` consecutive cycles in each conversion and is low at every other time.
- R2: `sck_o` is never high while `cnv_o` is high. The first rising edge of `sck_o` in a conversion comes at least `CONV_WAIT_CYC` cycles after the rising edge of `cnv_o`.
- R3: Every high phase of `sck_o`, and every low phase between two rising edges in a conversion, lasts exactly `SCK_HALF_CYC` cycles. Each conversion has exactly 13 rising edges, and `sck_o` is low outside readout.
- R4: Both data lines are sampled in the cycle in which `sck_o` is about to rise. The value each line carries before that rising edge is the bit taken. Bits arrive sign bit first, then from the most significant magnitude bit down to bit 0. Line A fills `res_a_o` and line B fills `res_b_o`.
- R5: Each result is a 13-bit two's-complement code, with bit 12 as the sign. It appears on a 16-bit output with bit 12 copied into bits 15:13. `res_vld_o` is high for exactly one cycle, the cycle right after the final falling edge of `sck_o`. The outputs hold their values until the next valid pulse.
- R6: Two rising edges of `cnv_o` are never closer than `CYCLE_MIN_CYC` cycles.
- R7: Any number of `start_i` pulses during a cycle, whether in readout or after it, add up to one pending request. That request raises `cnv_o` exactly `CYCLE_MIN_CYC` cycles after the previous rising edge. Once the request is carried out, no further conversion follows.
- R8: While `free_run_i` is high, conversions follow one another with rising edges of `cnv_o` exactly `CYCLE_MIN_CYC` cycles apart. If `free_run_i` is lowered before the end of the current cycle, that cycle completes and no new one starts.
- R9: `busy_o` is high from the first cycle of `cnv_o` high until the minimum cycle has run out, so it covers every cycle with `cnv_o` or `sck_o` high. After reset, `cnv_o`, `sck_o`, `busy_o`, `res_vld_o` and both results are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Single-cycle conversion request |
| free_run_i | input | 1 | Level: convert continuously at the minimum period |
| sdo_a_i | input | 1 | Serial data line of channel A |
| sdo_b_i | input | 1 | Serial data line of channel B |
| cnv_o | output | 1 | Convert strobe to the converter |
| sck_o | output | 1 | Shift clock to the converter |
| busy_o | output | 1 | A conversion cycle is in progress |
| res_vld_o | output | 1 | One-cycle pulse: both results updated |
| res_a_o | output | 16 | Channel A result, sign-extended |
| res_b_o | output | 16 | Channel B result, sign-extended |

## Verification
The assertions assume that the parameters have passed the elaboration guards. They also assume reset is applied before the first request. The data lines and the request inputs need not follow any timing, because every checked property concerns only the strobe and clock pattern that the block itself generates. The stimulus changes requests and data only on falling clock edges. A converter model shifts preset codes out after the strobe falls and after each falling shift-clock edge, and drives a fixed level while the strobe is high. Every code pair is queued only for a conversion the stimulus actually requests, so any extra conversion or any missing result shows up in the scoreboard.

// File: rtl/adcrd_pkg.sv
`timescale 1ns/1ps
package adcrd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CNVH,
        ST_WAIT,
        ST_SHIFT,
        ST_DONE,
        ST_HOLD
    } seq_st_t;

endpackage

// File: rtl/adcrd_sck_gen.sv
`timescale 1ns/1ps
module adcrd_sck_gen #(
    parameter int HALF_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic sck_o,
    output logic rise_stb_o,
    output logic fall_stb_o
);
    localparam int PH_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

    typedef struct packed {
        logic            sck;
        logic [PH_W-1:0] ph;
    } gen_t;

    gen_t gen_d, gen_q;

    always_comb begin
        gen_d      = gen_q;
        rise_stb_o = 1'b0;
        fall_stb_o = 1'b0;
        if (!en_i) begin
            gen_d.sck = 1'b0;
            gen_d.ph  = '0;
        end else if (gen_q.ph == PH_W'(HALF_CYC - 1)) begin
            gen_d.ph   = '0;
            gen_d.sck  = !gen_q.sck;
            rise_stb_o = !gen_q.sck;
            fall_stb_o = gen_q.sck;
        end else begin
            gen_d.ph = gen_q.ph + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gen_q <= '0;
        else        gen_q <= gen_d;
    end

    assign sck_o = gen_q.sck;

    // R3: a toggle strobe only ever comes from an enabled generator
    a_r3_stb_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_stb_o || fall_stb_o) |-> en_i);

    // R3: the clock stays low whenever the generator was disabled
    a_r3_low_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !sck_o);

endmodule

// File: rtl/adcrd_capture.sv
`timescale 1ns/1ps
module adcrd_capture #(
    parameter int W = 13
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_i,
    input  logic         sdo_i,
    output logic [W-1:0] word_o
);
    typedef struct packed {
        logic [W-1:0] sr;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d = cap_q;
        if (shift_i) cap_d.sr = {cap_q.sr[W-2:0], sdo_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign word_o = cap_q.sr;

    // R4: the newest bit lands in the LSB, older bits move up
    a_r4_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
        shift_i |=> (word_o[0] == $past(sdo_i)) && (word_o[W-1:1] == $past(word_o[W-2:0])));

    // R4: without a strobe the word is held
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_i |=> $stable(word_o));

endmodule

// File: rtl/adc_dual_readout.sv
`timescale 1ns/1ps
module adc_dual_readout #(
    parameter int CLK_PS           = 5000,
    parameter int CNV_HI_CYC       = 7,
    parameter int CONV_WAIT_CYC    = 45,
    parameter int SCK_HALF_CYC     = 2,
    parameter int CYCLE_MIN_CYC    = 100,
    parameter int RES_BITS         = 13,
    parameter int OUT_W            = 16,
    parameter int MIN_CNV_HI_PS    = 30000,
    parameter int MIN_CONV_PS      = 220000,
    parameter int MIN_CYCLE_PS     = 500000,
    parameter int MIN_SCK_PHASE_PS = 7000,
    parameter int MIN_SCK_PER_PS   = 15600
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             free_run_i,
    input  logic             sdo_a_i,
    input  logic             sdo_b_i,
    output logic             cnv_o,
    output logic             sck_o,
    output logic             busy_o,
    output logic             res_vld_o,
    output logic [OUT_W-1:0] res_a_o,
    output logic [OUT_W-1:0] res_b_o
);
    import adcrd_pkg::*;

    localparam int NCH     = 2;
    localparam int CYC_W   = $clog2(CYCLE_MIN_CYC + 1);
    localparam int BIT_W   = $clog2(RES_BITS + 1);
    localparam int EXT_W   = OUT_W - RES_BITS;
    localparam int READ_CYC = CONV_WAIT_CYC + 2 * SCK_HALF_CYC * RES_BITS + 2;

    // elaboration guards on the timing budget
    if (CNV_HI_CYC * CLK_PS < MIN_CNV_HI_PS) begin : g_bad_cnv_hi
        $error("convert-high time below converter minimum");
    end
    if (CONV_WAIT_CYC * CLK_PS < MIN_CONV_PS) begin : g_bad_conv
        $error("conversion wait shorter than worst-case conversion");
    end
    if (CONV_WAIT_CYC <= CNV_HI_CYC) begin : g_bad_order
        $error("conversion wait must end after the strobe falls");
    end
    if (SCK_HALF_CYC * CLK_PS < MIN_SCK_PHASE_PS ||
        2 * SCK_HALF_CYC * CLK_PS < MIN_SCK_PER_PS) begin : g_bad_sck
        $error("shift clock phase or period too short");
    end
    if (CYCLE_MIN_CYC * CLK_PS < MIN_CYCLE_PS) begin : g_bad_rate
        $error("cycle period below converter minimum");
    end
    if (READ_CYC > CYCLE_MIN_CYC) begin : g_bad_budget
        $error("readout does not fit in the minimum cycle");
    end
    if (EXT_W < 1) begin : g_bad_width
        $error("output must be wider than the code");
    end

    typedef struct packed {
        seq_st_t          st;
        logic [CYC_W-1:0] cyc;
        logic [BIT_W-1:0] bits;
        logic             pend;
        logic             cnv;
        logic             vld;
        logic [OUT_W-1:0] res_a;
        logic [OUT_W-1:0] res_b;
    } seq_t;

    seq_t seq_d, seq_q;
    logic launch;
    logic rise_stb, fall_stb, sck;
    logic [NCH-1:0]      sdo_vec;
    logic [RES_BITS-1:0] word [NCH];

    function automatic logic [OUT_W-1:0] sext(input logic [RES_BITS-1:0] w);
        return {{EXT_W{w[RES_BITS-1]}}, w};
    endfunction

    adcrd_sck_gen #(.HALF_CYC(SCK_HALF_CYC)) u_sck (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (seq_q.st == ST_SHIFT),
        .sck_o     (sck),
        .rise_stb_o(rise_stb),
        .fall_stb_o(fall_stb)
    );

    assign sdo_vec = {sdo_b_i, sdo_a_i};

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        adcrd_capture #(.W(RES_BITS)) u_cap (
            .clk    (clk),
            .rst_n  (rst_n),
            .shift_i(rise_stb),
            .sdo_i  (sdo_vec[g]),
            .word_o (word[g])
        );
    end

    always_comb begin
        seq_d     = seq_q;
        seq_d.vld = 1'b0;
        launch    = 1'b0;
        if (seq_q.st != ST_IDLE && seq_q.cyc != CYC_W'(CYCLE_MIN_CYC - 1))
            seq_d.cyc = seq_q.cyc + 1'b1;
        if (start_i && seq_q.st != ST_IDLE)
            seq_d.pend = 1'b1;
        unique case (seq_q.st)
            ST_IDLE: launch = start_i | free_run_i;
            ST_CNVH: begin
                if (seq_q.cyc == CYC_W'(CNV_HI_CYC - 1)) begin
                    seq_d.cnv = 1'b0;
                    seq_d.st  = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (seq_q.cyc >= CYC_W'(CONV_WAIT_CYC - 1)) begin
                    seq_d.st   = ST_SHIFT;
                    seq_d.bits = '0;
                end
            end
            ST_SHIFT: begin
                if (rise_stb)
                    seq_d.bits = seq_q.bits + 1'b1;
                if (fall_stb && seq_q.bits == BIT_W'(RES_BITS))
                    seq_d.st = ST_DONE;
            end
            ST_DONE: begin
                seq_d.vld   = 1'b1;
                seq_d.res_a = sext(word[0]);
                seq_d.res_b = sext(word[1]);
                seq_d.st    = ST_HOLD;
            end
            ST_HOLD: begin
                if (seq_q.cyc == CYC_W'(CYCLE_MIN_CYC - 1)) begin
                    if (start_i || free_run_i || seq_q.pend) launch = 1'b1;
                    else                                     seq_d.st = ST_IDLE;
                end
            end
            default: seq_d.st = ST_IDLE;
        endcase
        if (launch) begin
            seq_d.st   = ST_CNVH;
            seq_d.cnv  = 1'b1;
            seq_d.cyc  = '0;
            seq_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q    <= '0;
            seq_q.st <= ST_IDLE;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign cnv_o     = seq_q.cnv;
    assign sck_o     = sck;
    assign busy_o    = (seq_q.st != ST_IDLE);
    assign res_vld_o = seq_q.vld;
    assign res_a_o   = seq_q.res_a;
    assign res_b_o   = seq_q.res_b;

    // run-length counters that support the timing properties
    logic [CYC_W-1:0] cnv_run_q, sck_run_q, gap_q;
    logic             cnv_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnv_run_q  <= '0;
            sck_run_q  <= '0;
            gap_q      <= CYC_W'(CYCLE_MIN_CYC);
            cnv_prev_q <= 1'b0;
        end else begin
            cnv_prev_q <= cnv_o;
            if (!cnv_o)                                 cnv_run_q <= '0;
            else if (cnv_run_q != CYC_W'(CYCLE_MIN_CYC)) cnv_run_q <= cnv_run_q + 1'b1;
            if (!sck_o)                                 sck_run_q <= '0;
            else if (sck_run_q != CYC_W'(CYCLE_MIN_CYC)) sck_run_q <= sck_run_q + 1'b1;
            if (cnv_o && !cnv_prev_q)                   gap_q <= CYC_W'(1);
            else if (gap_q != CYC_W'(CYCLE_MIN_CYC))     gap_q <= gap_q + 1'b1;
        end
    end

    a_r1_cnv_width: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cnv_o) |-> cnv_run_q == CYC_W'(CNV_HI_CYC));

    a_r2_sck_not_in_cnv: assert property (@(posedge clk) disable iff (!rst_n)
        sck_o |-> !cnv_o);

    a_r2_conv_wait: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sck_o) |-> seq_q.cyc >= CYC_W'(CONV_WAIT_CYC));

    a_r3_high_phase: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sck_o) |-> sck_run_q == CYC_W'(SCK_HALF_CYC));

    a_r5_vld_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld_o |=> !res_vld_o);

    a_r5_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
        !res_vld_o |-> $stable(res_a_o) && $stable(res_b_o));

    a_r6_min_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cnv_o) |-> gap_q >= CYC_W'(CYCLE_MIN_CYC));

    a_r9_busy_cover: assert property (@(posedge clk) disable iff (!rst_n)
        (cnv_o || sck_o) |-> busy_o);

endmodule

// File: tb/adc_dual_readout_bench.sv
`timescale 1ns/1ps
module adc_dual_readout_bench;
    localparam int CNVH   = 7;
    localparam int CWAIT  = 45;
    localparam int HALF   = 2;
    localparam int CYCMIN = 120;
    localparam int NB     = 13;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, free_run = 1'b0;
    logic sdo_a = 1'b1, sdo_b = 1'b1;
    logic cnv, sck, busy, vld;
    logic [15:0] ra, rb;

    adc_dual_readout #(.CONV_WAIT_CYC(CWAIT), .CNV_HI_CYC(CNVH),
                       .SCK_HALF_CYC(HALF), .CYCLE_MIN_CYC(CYCMIN)) u_adc_dual_readout (
        .clk(clk), .rst_n(rst_n), .start_i(start), .free_run_i(free_run),
        .sdo_a_i(sdo_a), .sdo_b_i(sdo_b), .cnv_o(cnv), .sck_o(sck),
        .busy_o(busy), .res_vld_o(vld), .res_a_o(ra), .res_b_o(rb));

    always #2.5 clk = ~clk;

    int n_chk = 0, n_fail = 0, n_vld = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // converter model and scoreboard queues
    logic [12:0] stim_a[$], stim_b[$];
    logic [15:0] exp_a[$], exp_b[$];
    logic [12:0] cur_a = '0, cur_b = '0;
    int  bidx = 0;
    logic cnv_seen = 1'b0;

    task automatic push(input logic [12:0] a, input logic [12:0] b);
        stim_a.push_back(a);  stim_b.push_back(b);
        exp_a.push_back({{3{a[12]}}, a});
        exp_b.push_back({{3{b[12]}}, b});
    endtask

    always @(posedge cnv or negedge cnv or negedge sck) begin
        if (cnv && !cnv_seen) begin
            if (stim_a.size() > 0) begin
                cur_a = stim_a.pop_front();
                cur_b = stim_b.pop_front();
            end else begin
                cur_a = '0;
                cur_b = '0;
            end
            sdo_a = 1'b1;
            sdo_b = 1'b1;
            bidx  = NB - 1;
        end else if (!cnv && cnv_seen) begin
            sdo_a = cur_a[NB-1];
            sdo_b = cur_b[NB-1];
        end else if (!cnv) begin
            bidx = bidx - 1;
            if (bidx >= 0) begin
                sdo_a = cur_a[bidx];
                sdo_b = cur_b[bidx];
            end
        end
        cnv_seen = cnv;
    end

    // monitor: timing and result comparison
    int cyc = 0, rise_last = -100000, rise_prev = -100000, hi_len = 0;
    int rises = 0, run = 0, last_fall = 0;
    logic cnv_p = 1'b0, sck_p = 1'b0, vld_p = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (cnv && !cnv_p) begin
                check(cyc - rise_last >= CYCMIN, "R6 convert spacing", cyc - rise_last, CYCMIN);
                check(busy, "R9 busy at convert", busy, 1);
                rise_prev = rise_last;
                rise_last = cyc;
                hi_len = 0;
                rises  = 0;
            end
            if (cnv) hi_len++;
            if (!cnv && cnv_p) check(hi_len == CNVH, "R1 convert high width", hi_len, CNVH);
            if (sck && cnv) check(0, "R2 shift clock during convert", 1, 0);
            if (sck != sck_p) begin
                if (sck) begin
                    if (rises == 0) check(cyc - rise_last >= CWAIT, "R2 first shift edge", cyc - rise_last, CWAIT);
                    else            check(run == HALF, "R3 low phase", run, HALF);
                    rises++;
                end else begin
                    check(run == HALF, "R3 high phase", run, HALF);
                    last_fall = cyc;
                end
                run = 1;
            end else begin
                run++;
            end
            if (vld) begin
                n_vld++;
                check(!vld_p, "R5 valid one cycle", vld_p, 0);
                check(rises == NB, "R3 edges per conversion", rises, NB);
                check(cyc - last_fall == 1, "R5 valid timing", cyc - last_fall, 1);
                if (exp_a.size() == 0) begin
                    check(0, "R7 unexpected conversion", 1, 0);
                end else begin
                    logic [15:0] ea, eb;
                    ea = exp_a.pop_front();
                    eb = exp_b.pop_front();
                    check(ra == ea, "R4 R5 channel A", ra, ea);
                    check(rb == eb, "R4 R5 channel B", rb, eb);
                end
            end
            cnv_p = cnv;
            sck_p = sck;
            vld_p = vld;
        end
    end

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (!busy) break;
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #500000;
        check(0, "R9 watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        int base;
        repeat (4) @(negedge clk);
        check(!cnv && !sck && !busy && !vld && ra == 0 && rb == 0, "R9 reset state",
              {cnv, sck, busy, vld}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // single conversions with contrasting codes
        push(13'h0000, 13'h1FFF); pulse_start(); wait_idle();
        push(13'h0FFF, 13'h1000); pulse_start(); wait_idle();
        push(13'h0123, 13'h1C05); pulse_start(); wait_idle();
        push(13'h1001, 13'h0001); pulse_start(); wait_idle();
        check(n_vld == 4, "R5 result count", n_vld, 4);

        // R7: repeated requests while busy collapse into one
        base = n_vld;
        push(13'h0555, 13'h1AAA);
        push(13'h0F0F, 13'h10F0);
        pulse_start();
        repeat (10) @(negedge clk);
        pulse_start();
        repeat (60) @(negedge clk);
        pulse_start();
        pulse_start();
        wait_idle();
        check(n_vld - base == 2, "R7 conversions run", n_vld - base, 2);
        check(rise_last - rise_prev == CYCMIN, "R7 pending launch spacing", rise_last - rise_prev, CYCMIN);
        repeat (3 * CYCMIN) @(negedge clk);
        check(n_vld - base == 2 && !busy, "R7 no extra conversion", n_vld - base, 2);

        // R8: free-running conversions
        base = n_vld;
        push(13'h0800, 13'h17FF);
        push(13'h0001, 13'h1FFE);
        push(13'h0A0A, 13'h0505);
        push(13'h1111, 13'h0EEE);
        @(negedge clk) free_run = 1'b1;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if (n_vld - base >= 4) break;
        end
        free_run = 1'b0;
        check(rise_last - rise_prev == CYCMIN, "R8 free-run spacing", rise_last - rise_prev, CYCMIN);
        wait_idle();
        repeat (2 * CYCMIN) @(negedge clk);
        check(n_vld - base == 4 && !busy, "R8 stops after release", n_vld - base, 4);
        check(exp_a.size() == 0, "R5 scoreboard drained", exp_a.size(), 0);
        check(!sck && !cnv, "R3 idle levels", {sck, cnv}, 0);
        finish_run();
    end
endmodule